// File: doc/BRIEF.md
# Three-Wire Serial Register Access Controller

This block is the host end of a serial link used to set up and read back the configuration registers of a data converter. It uses one shared, bidirectional data line. A local client requests an access with a one-cycle start pulse, together with a read/write flag, a register address and, for writes, a data byte. The block builds the serial frame. It generates the serial clock by dividing the system clock, and it holds the active-low chip select low for the whole frame. When the frame has finished, it reports completion with a one-cycle done pulse and presents the captured byte on reads.

Each frame has 24 bits, and every field is sent most significant bit first. The first bit is the direction flag (1 = read). The next two bits give the word length and are always 00, which means one byte. A 13-bit register address follows, and then 8 data bits. On a read, the block drives the line only for the 16 instruction bits. It lets go of the line on the falling clock edge after the last address bit, so that the converter can drive the data bits back.

Top module: `spi3_ctrl`

## Requirements
- R1: Out of reset, and whenever no access is in progress, cs_n is 1, sclk is 0, sdio_oe is 0, done is 0 and busy is 0.
- R2: An access keeps cs_n low for exactly 24 sclk rising edges. The bits presented at those edges are, in order: the direction bit (0 write, 1 read), two word-length bits, the 13 address bits MSB first, and the 8 data bits MSB first.
- R3: Inside a frame, each sclk high level and each sclk low level lasts HALF system cycles. HALF is the smallest count that keeps the sclk period at or above 1/SCLK_MAX_MHZ; it is 2 cycles with the defaults (100 MHz system clock, 40 ns sclk).
- R4: While cs_n is low and sclk is high, sdio_o does not change. Outgoing bits change only together with a falling edge of sclk.
- R5: sdio_oe rises only as cs_n falls. On a write it stays high for all 24 bits. On a read it falls together with the sclk falling edge that follows the 16th rising edge, and it is never high while cs_n is high.
- R6: On a read, the values on sdio_i at rising edges 17 to 24 form rdata, MSB first. Each access ends with exactly one done pulse of a single cycle, given with cs_n already high and with rdata valid in the same cycle.
- R7: A start pulse that arrives while busy is 1 is ignored. No second frame is produced, and no register is changed by it.
- R8: Between two frames, cs_n stays high for at least one full sclk period (2*HALF cycles), even when a new start arrives in the cycle that follows done.
- R9: The two word-length bits of every instruction are 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request pulse, accepted only when idle |
| rw | input | 1 | Access direction, 1 = read, sampled with start |
| addr | input | ADDR_W | Register address, sampled with start |
| wdata | input | DATA_W | Write byte, sampled with start |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Byte captured by the last read |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| sdio_o | output | 1 | Value to drive onto the shared data line |
| sdio_oe | output | 1 | Driver enable for the shared data line |
| sdio_i | input | 1 | Value read back from the shared data line |

## Verification
The bound assertions watch properties that hold on every cycle:
- the idle pin levels;
- the exact length of each sclk half period;
- outgoing data holding still while sclk is high;
- the driver enable rising only with chip select;
- done being a single cycle;
- the minimum chip-select high time between frames.

Other properties can only be shown by the bench's scenarios against a model of the converter with its own register file. These are:
- the bit content of the frames;
- a write followed by a read returning the stored byte;
- the exact rising edge after which the line turns around;
- the absence of cycles where both sides drive the line;
- a start pulse during a frame being dropped.

// File: rtl/spi3_pkg.sv
package spi3_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_GAP
    } spi3_state_e;

    // Word-length field value selecting a single byte per access
    localparam logic [1:0] WORD_LEN_ONE = 2'b00;

    // System cycles per sclk half period so that the period is >= 1/max rate
    function automatic int half_cycles(input int sys_mhz, input int max_mhz);
        int h;
        h = (sys_mhz * 500 + max_mhz * 1000 - 1) / (max_mhz * 1000);
        return (h < 1) ? 1 : h;
    endfunction

endpackage

// File: rtl/spi3_halfdiv.sv
module spi3_halfdiv #(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (!en) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            tick  = 1'b1;
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi3_txsr.sv
module spi3_txsr #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load)       sr_d = load_val;
        else if (shift) sr_d = {sr_q[W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign msb = sr_q[W-1];
endmodule

// File: rtl/spi3_rxsr.sv
module spi3_rxsr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic         in_bit,
    output logic [W-1:0] q
);
    logic [W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (clr)        sr_d = '0;
        else if (shift) sr_d = {sr_q[W-2:0], in_bit};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign q = sr_q;
endmodule

// File: rtl/spi3_ctrl.sv
module spi3_ctrl
    import spi3_pkg::*;
#(
    parameter int SYS_CLK_MHZ  = 100,
    parameter int SCLK_MAX_MHZ = 25,
    parameter int ADDR_W       = 13,
    parameter int DATA_W       = 8,
    parameter int GAP_HALVES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              sclk,
    output logic              cs_n,
    output logic              sdio_o,
    output logic              sdio_oe,
    input  logic              sdio_i
);
    localparam int INSTR_W  = 3 + ADDR_W;
    localparam int FRAME_W  = INSTR_W + DATA_W;
    localparam int CNT_W    = $clog2(FRAME_W);
    localparam int GAP_W    = $clog2(GAP_HALVES + 1);
    localparam int HALF_CYC = half_cycles(SYS_CLK_MHZ, SCLK_MAX_MHZ);

    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] TURN_BIT  = CNT_W'(INSTR_W - 1);
    localparam logic [CNT_W-1:0] FIRST_RX  = CNT_W'(INSTR_W);
    localparam logic [GAP_W-1:0] GAP_LAST  = GAP_W'(GAP_HALVES - 1);

    typedef struct packed {
        spi3_state_e      st;
        logic             sclk;
        logic             cs_n;
        logic             oe;
        logic             rw;
        logic [CNT_W-1:0] bit_cnt;
        logic [GAP_W-1:0] gap_cnt;
        logic             done;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{
        st: ST_IDLE, sclk: 1'b0, cs_n: 1'b1, oe: 1'b0, rw: 1'b0,
        bit_cnt: '0, gap_cnt: '0, done: 1'b0
    };

    ctrl_t r_d, r_q;

    logic tick;
    logic div_en;
    logic tx_load, tx_shift;
    logic rx_clr, rx_shift;
    logic [FRAME_W-1:0] frame_val;

    assign frame_val = {rw, WORD_LEN_ONE, addr, wdata};
    assign div_en    = (r_q.st != ST_IDLE);

    spi3_halfdiv #(
        .HALF_CYC (HALF_CYC)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (div_en),
        .tick  (tick)
    );

    spi3_txsr #(
        .W (FRAME_W)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tx_load),
        .load_val (frame_val),
        .shift    (tx_shift),
        .msb      (sdio_o)
    );

    spi3_rxsr #(
        .W (DATA_W)
    ) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (rx_clr),
        .shift  (rx_shift),
        .in_bit (sdio_i),
        .q      (rdata)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tx_load  = 1'b0;
        tx_shift = 1'b0;
        rx_clr   = 1'b0;
        rx_shift = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st      = ST_LEAD;
                    r_d.cs_n    = 1'b0;
                    r_d.oe      = 1'b1;
                    r_d.rw      = rw;
                    r_d.sclk    = 1'b0;
                    r_d.bit_cnt = '0;
                    tx_load     = 1'b1;
                    rx_clr      = 1'b1;
                end
            end
            ST_LEAD: begin
                // first bit is already on the line; raise the first edge
                if (tick) begin
                    r_d.st   = ST_SHIFT;
                    r_d.sclk = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (r_q.sclk) begin
                        r_d.sclk = 1'b0;
                        if (r_q.bit_cnt == LAST_BIT) begin
                            r_d.st      = ST_GAP;
                            r_d.cs_n    = 1'b1;
                            r_d.oe      = 1'b0;
                            r_d.gap_cnt = '0;
                        end else begin
                            r_d.bit_cnt = r_q.bit_cnt + 1'b1;
                            tx_shift    = 1'b1;
                            // hand the line to the peripheral after the address
                            if (r_q.rw && (r_q.bit_cnt == TURN_BIT)) begin
                                r_d.oe = 1'b0;
                            end
                        end
                    end else begin
                        r_d.sclk = 1'b1;
                        if (r_q.rw && (r_q.bit_cnt >= FIRST_RX)) begin
                            rx_shift = 1'b1;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (r_q.gap_cnt == GAP_LAST) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.gap_cnt = r_q.gap_cnt + 1'b1;
                    end
                end
            end
            default: r_d = CTRL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= CTRL_RST;
        else        r_q <= r_d;
    end

    assign busy    = (r_q.st != ST_IDLE);
    assign done    = r_q.done;
    assign sclk    = r_q.sclk;
    assign cs_n    = r_q.cs_n;
    assign sdio_oe = r_q.oe;
endmodule

// File: rtl/spi3_ctrl_chk.sv
module spi3_ctrl_chk
    import spi3_pkg::*;
#(
    parameter int SYS_CLK_MHZ  = 100,
    parameter int SCLK_MAX_MHZ = 25
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic sclk,
    input logic cs_n,
    input logic sdio_o,
    input logic sdio_oe
);
    localparam int HALF = half_cycles(SYS_CLK_MHZ, SCLK_MAX_MHZ);

    logic        sclk_prev;
    logic [15:0] run_q;
    logic [15:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            run_q     <= '0;
            hi_q      <= '0;
        end else begin
            sclk_prev <= sclk;
            if (cs_n)                   run_q <= '0;
            else if (sclk != sclk_prev) run_q <= 16'd1;
            else if (run_q != 16'hFFFF) run_q <= run_q + 16'd1;
            if (!cs_n)                  hi_q  <= '0;
            else if (hi_q != 16'hFFFF)  hi_q  <= hi_q + 16'd1;
        end
    end

    // R1
    idle_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!sdio_oe && !sclk));

    // R1
    idle_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);

    // R3
    half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && (sclk != sclk_prev)) |-> (run_q == 16'(HALF)));

    // R4
    sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && sclk) |-> $stable(sdio_o));

    // R5
    oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdio_oe) |-> $fell(cs_n));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n);

    // R8
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_q >= 16'(2 * HALF)));
endmodule

bind spi3_ctrl spi3_ctrl_chk #(
    .SYS_CLK_MHZ  (SYS_CLK_MHZ),
    .SCLK_MAX_MHZ (SCLK_MAX_MHZ)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .sclk    (sclk),
    .cs_n    (cs_n),
    .sdio_o  (sdio_o),
    .sdio_oe (sdio_oe)
);

// File: tb/spi3_ctrl_tb.sv
`timescale 1ns/1ps
module spi3_ctrl_tb;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rw = 1'b0;
    logic [12:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        busy, done, sclk, cs_n, sdio_o, sdio_oe, sdio_i;
    logic [7:0]  rdata;

    // peripheral model state
    logic        p_oe = 1'b0;
    logic        p_bit = 1'b0;
    logic [7:0]  mem [16];
    logic [23:0] p_sh = '0;
    logic [15:0] p_instr = '0;
    int          p_cnt = 0;

    // monitors
    logic prev_sclk = 1'b0, prev_sdo = 1'b0, prev_oe = 1'b0, prev_cs = 1'b1;
    int rises = 0, oe_drop_at = -1, contention = 0, sdo_hi_chg = 0;
    logic oe_drop_sclk = 1'b1;
    int min_half = 1000000, max_half = 0, half_run = 0;
    int cs_hi_run = 0, min_gap = 1000000, frames = 0;
    bit gap_valid = 1'b0;

    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    assign sdio_i = sdio_oe ? sdio_o : (p_oe ? p_bit : 1'b0);

    spi3_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rw(rw), .addr(addr),
        .wdata(wdata), .busy(busy), .done(done), .rdata(rdata), .sclk(sclk),
        .cs_n(cs_n), .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdio_i(sdio_i)
    );

    always @(negedge clk) begin
        if (sdio_oe && p_oe) contention++;
        if (!cs_n && sclk && prev_sclk && (sdio_o != prev_sdo)) sdo_hi_chg++;
        if (prev_cs && !cs_n) begin
            rises = 0; oe_drop_at = -1; frames++; half_run = 0;
            if (gap_valid && cs_hi_run < min_gap) min_gap = cs_hi_run;
        end
        if (cs_n) cs_hi_run++; else cs_hi_run = 0;
        if (!prev_cs && cs_n) gap_valid = 1'b1;
        if (!cs_n) begin
            if (sclk != prev_sclk) begin
                if (half_run < min_half) min_half = half_run;
                if (half_run > max_half) max_half = half_run;
                half_run = 1;
            end else begin
                half_run++;
            end
            if (prev_oe && !sdio_oe) begin
                oe_drop_at = rises; oe_drop_sclk = sclk;
            end
        end
        // peripheral: sample on rise, drive on fall
        if (cs_n) begin
            p_oe = 1'b0; p_cnt = 0;
        end else if (sclk && !prev_sclk) begin
            rises++;
            p_sh = {p_sh[22:0], sdio_i};
            p_cnt++;
            if (p_cnt == 16) p_instr = p_sh[15:0];
            if (p_cnt == 24 && !p_instr[15]) mem[p_instr[3:0]] = p_sh[7:0];
        end else if (!sclk && prev_sclk) begin
            if (p_instr[15] && p_cnt >= 16 && p_cnt < 24) begin
                p_oe  = 1'b1;
                p_bit = mem[p_instr[3:0]][7 - (p_cnt - 16)];
            end
        end
        prev_sclk = sclk; prev_sdo = sdio_o; prev_oe = sdio_oe; prev_cs = cs_n;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic r, input logic [12:0] a, input logic [7:0] d,
                        output logic [7:0] rd, output int dcount);
        int t;
        @(negedge clk);
        start = 1'b1; rw = r; addr = a; wdata = d;
        @(negedge clk);
        start = 1'b0;
        t = 0; dcount = 0;
        while (!done && t < 1000) begin
            @(negedge clk);
            t++;
        end
        rd = rdata;
        if (done) dcount = 1;
        @(negedge clk);
        if (done) dcount++;
    endtask

    task automatic t_reset();
        chk(cs_n == 1'b1, "R1 cs_n", int'(cs_n), 1);
        chk(sclk == 1'b0, "R1 sclk", int'(sclk), 0);
        chk(sdio_oe == 1'b0, "R1 sdio_oe", int'(sdio_oe), 0);
        chk(done == 1'b0 && busy == 1'b0, "R1 done/busy", int'({done, busy}), 0);
    endtask

    task automatic t_write(input logic [12:0] a, input logic [7:0] d);
        logic [7:0] rd; int dc;
        contention = 0; sdo_hi_chg = 0; min_half = 1000000; max_half = 0;
        xfer(1'b0, a, d, rd, dc);
        chk(rises == 24, "R2 write rising edges", rises, 24);
        chk(p_instr == {1'b0, 2'b00, a}, "R2 write instruction", int'(p_instr), int'({1'b0, 2'b00, a}));
        chk(p_instr[14:13] == 2'b00, "R9 word length", int'(p_instr[14:13]), 0);
        chk(mem[a[3:0]] == d, "R2 written byte", int'(mem[a[3:0]]), int'(d));
        chk(oe_drop_at == -1, "R5 write keeps driver", oe_drop_at, -1);
        chk(sdo_hi_chg == 0, "R4 sdio_o stable while sclk high", sdo_hi_chg, 0);
        chk(min_half == HALF && max_half == HALF, "R3 half period", min_half * 100 + max_half, HALF * 101);
        chk(dc == 1, "R6 done pulse count", dc, 1);
        chk(contention == 0, "R5 bus contention", contention, 0);
    endtask

    task automatic t_read(input logic [12:0] a, input logic [7:0] exp);
        logic [7:0] rd; int dc;
        contention = 0;
        xfer(1'b1, a, 8'h00, rd, dc);
        chk(rd == exp, "R6 read data", int'(rd), int'(exp));
        chk(p_instr == {1'b1, 2'b00, a}, "R2 read instruction", int'(p_instr), int'({1'b1, 2'b00, a}));
        chk(oe_drop_at == 16, "R5 turnaround edge", oe_drop_at, 16);
        chk(oe_drop_sclk == 1'b0, "R5 released with sclk low", int'(oe_drop_sclk), 0);
        chk(contention == 0, "R5 bus contention on read", contention, 0);
        chk(dc == 1, "R6 done pulse count read", dc, 1);
    endtask

    task automatic t_busy_ignore();
        int f0, t, dones;
        logic [7:0] keep;
        keep = mem[6];
        f0 = frames;
        @(negedge clk);
        start = 1'b1; rw = 1'b0; addr = 13'h0005; wdata = 8'h5A;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        start = 1'b1; addr = 13'h0006; wdata = 8'hFF;
        @(negedge clk);
        start = 1'b0;
        dones = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (done) dones++;
        end
        t = frames - f0;
        chk(t == 1, "R7 frames while busy", t, 1);
        chk(dones == 1, "R7 done count", dones, 1);
        chk(mem[6] == keep, "R7 ignored request left register", int'(mem[6]), int'(keep));
        chk(mem[5] == 8'h5A, "R7 accepted request applied", int'(mem[5]), 8'h5A);
    endtask

    task automatic t_back_to_back();
        logic [7:0] rd; int dc;
        min_gap = 1000000;
        xfer(1'b0, 13'h0009, 8'h77, rd, dc);
        xfer(1'b1, 13'h0009, 8'h00, rd, dc);
        chk(min_gap >= 2 * HALF, "R8 chip select gap", min_gap, 2 * HALF);
        chk(rd == 8'h77, "R6 back-to-back read", int'(rd), 8'h77);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 8'(i * 37 + 1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_write(13'h0003, 8'hA5);
        t_read(13'h0003, 8'hA5);
        t_write(13'h1FFC, 8'h3C);
        t_read(13'h1FFC, 8'h3C);
        t_read(13'h000B, 8'(11 * 37 + 1));
        t_busy_ignore();
        t_back_to_back();
        repeat (5) @(negedge clk);
        t_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule